// File: doc/BRIEF.md
# UART Sleep Entry Controller

This block decides when a multi-channel UART (two channels by default) may stop its oscillator and when it must restart it. Each channel reports five idle indications: interrupt status, a 16-bit baud divisor, a sleep-enable bit, the four modem-status change bits and its serial receive line. The block reduces each channel's indications to one idle flag and ANDs the flags of all channels. The result drives a small state machine. That machine controls two power outputs: an oscillator enable and a charge-pump enable for the line transceiver.

The machine has four states:
- `ST_RUN`: oscillator running.
- `ST_OSC_OFF`: oscillator stopped, charge pump not yet changed.
- `ST_SLEEP`: both outputs at their sleep levels.
- `ST_PUMP_UP`: charge pump restored, oscillator still stopped.

Transitions:
- `ST_RUN` goes to `ST_OSC_OFF` when every channel is idle.
- `ST_OSC_OFF` goes to `ST_SLEEP` if the idle condition still holds, or straight back to `ST_RUN` if it has dropped.
- `ST_SLEEP` goes to `ST_PUMP_UP` as soon as any channel stops being idle.
- `ST_PUMP_UP` always goes to `ST_RUN` on the next cycle.

An auto-pump input selects whether the charge pump follows the sleep state (high) or stays on at all times (low). A transceiver-off input gives the second partial mode: with auto-pump high, the UART keeps running while the charge pump is off. With auto-pump high, the UART asleep and the pump off, the block is in full sleep.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: A channel is idle only while its `irq_clear` bit is 1 (1 means no interrupt pending); a 0 on any channel keeps or brings the oscillator on.
- R2: A channel whose 16-bit `baud_div` is 0 blocks sleep; any non-zero value, including 16'h0001, allows it.
- R3: A channel whose `sleep_ena` bit is 0 blocks sleep.
- R4: Any of the four `msr_delta` bits of any channel being 1 blocks sleep.
- R5: A channel's `rxd` must be at the idle level (parameter `RX_IDLE`, default 0). `rxd` passes through two flip-flops, so a change reaches the state machine on the third rising edge after it is applied.
- R6: The oscillator stops only when all five conditions hold on every channel at once. `ST_RUN` moves to `ST_OSC_OFF` on the first edge where this is true.
- R7: On entry, `osc_en` falls one cycle before the charge pump is allowed to fall: `ST_OSC_OFF` keeps the running pump level, and `ST_SLEEP` applies the sleep level.
- R8: Waking from `ST_SLEEP` passes through `ST_PUMP_UP`. `pump_en` is 1 one cycle before `osc_en` returns to 1.
- R9: If the idle condition drops while in `ST_OSC_OFF`, the next edge returns to `ST_RUN` with `osc_en` = 1, and the pump is never lowered.
- R10: While `auto_pump` is 0, `pump_en` is 1 in every state.
- R11: With `auto_pump` = 1, `pump_en` is 0 in `ST_SLEEP`. In `ST_RUN` and `ST_OSC_OFF` it is 0 exactly when `xcvr_off` is 1.
- R12: After reset the machine is in `ST_RUN`: `osc_en` = 1 and `pump_en` = NOT(`auto_pump` AND `xcvr_off`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_clear | input | NUM_CH | Per channel: 1 = no interrupt pending |
| baud_div | input | NUM_CH x 16 | Per-channel baud divisor (high and low bytes combined) |
| sleep_ena | input | NUM_CH | Per-channel sleep-enable bit |
| msr_delta | input | NUM_CH x 4 | Per-channel modem-status change bits |
| rxd | input | NUM_CH | Per-channel asynchronous receive data line |
| auto_pump | input | 1 | 1 = charge pump follows sleep; 0 = pump always on |
| xcvr_off | input | 1 | Request pump off while the UART runs (used when auto_pump = 1) |
| osc_en | output | 1 | UART oscillator enable |
| pump_en | output | 1 | Transceiver charge-pump enable |

## Verification
State changes caused by `irq_clear`, `baud_div`, `sleep_ena` and `msr_delta` appear on `osc_en` and `pump_en` one rising edge after the input changes. A change on `rxd` appears three edges later. A change on `auto_pump` or `xcvr_off` shows on `pump_en` before the next edge, because the outputs are decoded from the state and those two pins.

The bench changes inputs on falling edges. For each of those cycles it queues one expected output pair. The monitor compares each pair just after the following rising edge. For `rxd` stimulus the queue holds the two unchanged cycles before the transition, so every item is matched to the exact edge at which it is due.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_OSC_OFF = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_PUMP_UP = 2'd3
    } slp_state_e;

    localparam int unsigned DIV_W   = 16;
    localparam int unsigned DELTA_W = 4;
endpackage

// File: rtl/slp_rx_sync.sv
module slp_rx_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic        INIT   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[s] <= {WIDTH{INIT}};
                end else if (s == 0) begin
                    pipe_q[s] <= d_async;
                end else begin
                    pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/slp_chan_idle.sv
module slp_chan_idle #(
    parameter logic RX_IDLE = 1'b0
) (
    input  logic                          irq_clear,
    input  logic [slp_pkg::DIV_W-1:0]     baud_div,
    input  logic                          sleep_ena,
    input  logic [slp_pkg::DELTA_W-1:0]   msr_delta,
    input  logic                          rx_sync,
    output logic                          idle
);
    logic div_ok;
    logic msr_quiet;
    logic rx_quiet;

    always_comb begin
        div_ok    = |baud_div;
        msr_quiet = ~|msr_delta;
        rx_quiet  = (rx_sync == RX_IDLE);
        idle      = irq_clear & div_ok & sleep_ena & msr_quiet & rx_quiet;
    end
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned SYNC_LEN = 2,
    parameter logic        RX_IDLE  = 1'b0
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_CH-1:0]                       irq_clear,
    input  logic [NUM_CH-1:0][slp_pkg::DIV_W-1:0]   baud_div,
    input  logic [NUM_CH-1:0]                       sleep_ena,
    input  logic [NUM_CH-1:0][slp_pkg::DELTA_W-1:0] msr_delta,
    input  logic [NUM_CH-1:0]                       rxd,
    input  logic                                    auto_pump,
    input  logic                                    xcvr_off,
    output logic                                    osc_en,
    output logic                                    pump_en
);
    import slp_pkg::*;

    logic [NUM_CH-1:0] rx_sync;
    logic [NUM_CH-1:0] chan_idle;
    logic              all_idle;
    logic              run_pump;
    slp_state_e        state_q, state_d;

    slp_rx_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_LEN), .INIT(RX_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rxd),
        .q_sync  (rx_sync)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            slp_chan_idle #(.RX_IDLE(RX_IDLE)) u_idle (
                .irq_clear (irq_clear[c]),
                .baud_div  (baud_div[c]),
                .sleep_ena (sleep_ena[c]),
                .msr_delta (msr_delta[c]),
                .rx_sync   (rx_sync[c]),
                .idle      (chan_idle[c])
            );
        end
    endgenerate

    assign all_idle = &chan_idle;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     state_d = all_idle ? ST_OSC_OFF : ST_RUN;
            ST_OSC_OFF: state_d = all_idle ? ST_SLEEP   : ST_RUN;
            ST_SLEEP:   state_d = all_idle ? ST_SLEEP   : ST_PUMP_UP;
            ST_PUMP_UP: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // Outputs
    assign run_pump = ~(auto_pump & xcvr_off);

    always_comb begin
        osc_en  = 1'b1;
        pump_en = 1'b1;
        unique case (state_q)
            ST_RUN:     begin osc_en = 1'b1; pump_en = run_pump;   end
            ST_OSC_OFF: begin osc_en = 1'b0; pump_en = run_pump;   end
            ST_SLEEP:   begin osc_en = 1'b0; pump_en = ~auto_pump; end
            ST_PUMP_UP: begin osc_en = 1'b0; pump_en = 1'b1;       end
            default:    begin osc_en = 1'b1; pump_en = 1'b1;       end
        endcase
    end
endmodule

// File: rtl/slp_chk.sv
module slp_chk (
    input logic                 clk,
    input logic                 rst_n,
    input slp_pkg::slp_state_e  state,
    input logic                 all_idle,
    input logic                 auto_pump,
    input logic                 osc_en,
    input logic                 pump_en
);
    import slp_pkg::*;

    // R10
    pump_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_pump |-> pump_en);

    // R6
    osc_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(all_idle));

    // R7
    sleep_via_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> ($past(state) == ST_SLEEP || $past(state) == ST_OSC_OFF));

    // R8
    pump_before_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUMP_UP) |-> (pump_en && !osc_en) ##1 osc_en);

    // R8
    no_direct_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SLEEP) |-> (state != ST_RUN));

    // R9
    abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OSC_OFF && !all_idle) |=> osc_en);
endmodule

bind uart_sleep_ctrl slp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .all_idle  (all_idle),
    .auto_pump (auto_pump),
    .osc_en    (osc_en),
    .pump_en   (pump_en)
);

// File: tb/sim_uart_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_uart_sleep_ctrl;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]       irq_clear = '1;
    logic [NCH-1:0][15:0] baud_div  = {16'd1, 16'd1};
    logic [NCH-1:0]       sleep_ena = '0;
    logic [NCH-1:0][3:0]  msr_delta = '0;
    logic [NCH-1:0]       rxd = '0;
    logic                 auto_pump = 1'b1;
    logic                 xcvr_off  = 1'b0;
    logic                 osc_en, pump_en;

    always #2.5 clk = ~clk;

    uart_sleep_ctrl #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_clear(irq_clear), .baud_div(baud_div),
        .sleep_ena(sleep_ena), .msr_delta(msr_delta), .rxd(rxd),
        .auto_pump(auto_pump), .xcvr_off(xcvr_off),
        .osc_en(osc_en), .pump_en(pump_en)
    );

    typedef struct { bit o; bit p; string tag; } exp_t;
    exp_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Driver side: queue the outputs due after the coming rising edge
    task automatic cyc(input bit eo, input bit ep, input string tag);
        exp_t e;
        e.o = eo; e.p = ep; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (osc_en !== e.o || pump_en !== e.p) begin
                    n_fail++;
                    $display("FAIL %s: osc_en/pump_en = %b%b expected %b%b",
                             e.tag, osc_en, pump_en, e.o, e.p);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, "R12 reset");
        // entry sequence
        sleep_ena = '1;
        cyc(0, 1, "R6/R7 osc off"); cyc(0, 0, "R7 sleep"); cyc(0, 0, "R7 hold");
        // interrupt wake on channel 1
        irq_clear[1] = 1'b0;
        cyc(0, 1, "R1/R8 pump up"); cyc(1, 1, "R8 run");
        irq_clear[1] = 1'b1;
        cyc(0, 1, "R6 osc off"); cyc(0, 0, "R7 sleep");
        // rxd wake, three edges latency
        rxd[0] = 1'b1;
        cyc(0, 0, "R5 sync1"); cyc(0, 0, "R5 sync2"); cyc(0, 1, "R5 pump up"); cyc(1, 1, "R5 run");
        rxd[0] = 1'b0;
        cyc(1, 1, "R5 sync1"); cyc(1, 1, "R5 sync2"); cyc(0, 1, "R5 osc off"); cyc(0, 0, "R5 sleep");
        // modem change wake, then aborted entry
        msr_delta[0] = 4'b0100;
        cyc(0, 1, "R4 pump up"); cyc(1, 1, "R4 run"); cyc(1, 1, "R4 hold");
        msr_delta[0] = 4'b0000;
        cyc(0, 1, "R6 osc off");
        msr_delta[1] = 4'b1000;
        cyc(1, 1, "R9 abort"); cyc(1, 1, "R4 hold bit3");
        msr_delta[1] = 4'b0000;
        cyc(0, 1, "R6 osc off"); cyc(0, 0, "R7 sleep");
        // divisor zero
        baud_div[1] = 16'd0;
        cyc(0, 1, "R2 pump up"); cyc(1, 1, "R2 run"); cyc(1, 1, "R2 hold");
        baud_div[1] = 16'h0001;
        cyc(0, 1, "R2 osc off"); cyc(0, 0, "R2 sleep");
        // sleep enable cleared on one channel
        sleep_ena[0] = 1'b0;
        cyc(0, 1, "R3 pump up"); cyc(1, 1, "R3 run"); cyc(1, 1, "R3 hold");
        // auto pump low
        auto_pump = 1'b0;
        cyc(1, 1, "R10 run");
        sleep_ena[0] = 1'b1;
        cyc(0, 1, "R10 osc off"); cyc(0, 1, "R10 sleep"); cyc(0, 1, "R10 hold");
        irq_clear[0] = 1'b0;
        cyc(0, 1, "R10 pump up"); cyc(1, 1, "R10 run");
        // transceiver off while running
        auto_pump = 1'b1; xcvr_off = 1'b1;
        cyc(1, 0, "R11 run pump off");
        auto_pump = 1'b0;
        cyc(1, 1, "R10 forced on");
        auto_pump = 1'b1; irq_clear[0] = 1'b1;
        cyc(0, 0, "R11 osc off"); cyc(0, 0, "R11 sleep");
        irq_clear[0] = 1'b0;
        cyc(0, 1, "R8 pump up"); cyc(1, 0, "R11 run");
        cyc(1, 0, "R11 hold");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule